// File: doc/BRIEF.md
# Bit Count Unit

This block computes one of three bit counts on an XLEN-bit source value: the number of zeros above the highest set bit (leading zeros), the number of zeros below the lowest set bit (trailing zeros), or the number of set bits (population count). A word flag restricts any of the three to the low 32 bits of the source when XLEN is 64. All counts have defined results for an all-zero source.

The unit is combinational up to a single output register. The caller presents the source, an operation code and the word flag together with a one-cycle valid strobe. The count appears one clock later, zero-extended to XLEN, together with an output valid pulse. The count holds its value until the next strobe. XLEN may be 32 or 64.

Top module: `bit_count_unit`

## Requirements
- R1: With op_i = 0 (leading zeros) and word_i = 0, count_o is the number of zero bits found scanning from bit XLEN-1 down to the first 1. A set MSB gives 0 and an all-zero source gives XLEN.
- R2: With op_i = 1 (trailing zeros) and word_i = 0, count_o is the number of zero bits found scanning upward from bit 0 to the first 1. A set bit 0 gives 0 and an all-zero source gives XLEN.
- R3: With op_i = 2 (population count) and word_i = 0, count_o is the number of 1 bits in src_i.
- R4: With op_i = 0 and word_i = 1, the scan starts at bit 31. An all-zero low word gives 32.
- R5: With op_i = 1 and word_i = 1, the scan ends at bit 31. An all-zero low word gives 32.
- R6: With op_i = 2 and word_i = 1, only bits 31..0 are counted.
- R7: With word_i = 1, bits XLEN-1..32 of src_i have no effect on count_o for any operation.
- R8: valid_o is high exactly in the cycle after a cycle with valid_i high, and count_o is updated in that same cycle. While valid_i is low, count_o holds its value.
- R9: op_i = 3 is reserved and gives count_o = 0.
- R10: After reset, valid_o is 0 and count_o is 0.
- R11: With XLEN = 32, word_i has no effect: every operation counts over all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe. Captures a new count. |
| op_i | input | 2 | Operation: 0 leading zeros, 1 trailing zeros, 2 population count, 3 reserved |
| word_i | input | 1 | Restrict the operation to bits 31..0 |
| src_i | input | XLEN | Source value |
| valid_o | output | 1 | Count valid, one cycle after valid_i |
| count_o | output | XLEN | Zero-extended count |

## Verification
The bench builds two instances side by side. The first uses XLEN = 64, where the word flag changes behaviour and the upper word can be set to disturb the low-word counts. The second uses XLEN = 32, where the word flag must be inert. Both instances are swept with every one-hot source position under every operation and word setting, with the all-zero and all-ones sources, and with random values. This covers each count value from 0 up to the full width, including the XLEN and 32 results for zero inputs.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    OP_LEAD  = 2'd0,
    OP_TRAIL = 2'd1,
    OP_POP   = 2'd2,
    OP_RSVD  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/bcu_prep.sv
// Shapes the source so one leading-zero counter serves both scan directions
// and both widths.
module bcu_prep
  import bcu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] src_i,
  input  cnt_op_e         op_i,
  input  logic            word_i,
  output logic [XLEN-1:0] scan_o,
  output logic [XLEN-1:0] pop_o
);
  logic [XLEN-1:0]   rev_full;
  logic [WORD_W-1:0] rev_word;

  always_comb begin
    for (int i = 0; i < XLEN; i++) rev_full[i] = src_i[XLEN-1-i];
    for (int i = 0; i < WORD_W; i++) rev_word[i] = src_i[WORD_W-1-i];
  end

  if (XLEN > WORD_W) begin : g_wide
    localparam int unsigned PAD = XLEN - WORD_W;
    // Padding ones below the word stop the scan at 32 for a zero word.
    always_comb begin
      if (word_i) begin
        scan_o = (op_i == OP_TRAIL) ? {rev_word, {PAD{1'b1}}}
                                    : {src_i[WORD_W-1:0], {PAD{1'b1}}};
        pop_o  = {{PAD{1'b0}}, src_i[WORD_W-1:0]};
      end else begin
        scan_o = (op_i == OP_TRAIL) ? rev_full : src_i;
        pop_o  = src_i;
      end
    end
  end else begin : g_narrow
    logic unused_word;
    logic [WORD_W-1:0] unused_rev;
    assign unused_word = word_i;
    assign unused_rev  = rev_word;
    assign scan_o = (op_i == OP_TRAIL) ? rev_full : src_i;
    assign pop_o  = src_i;
  end
endmodule

// File: rtl/bcu_lzc.sv
module bcu_lzc #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // Higher set bits overwrite lower ones: the last hit is the highest.
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

  always_comb begin
    if (vec_i[W-1]) assert (cnt_o == '0);  // R1: MSB set gives zero
  end
endmodule

// File: rtl/bcu_popcnt.sv
module bcu_popcnt #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end

  always_comb begin
    if (&vec_i) assert (cnt_o == CW'(W));  // R3: all ones counts W
  end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
  import bcu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] src_i,
  output logic            valid_o,
  output logic [XLEN-1:0] count_o
);
  localparam int unsigned CW = $clog2(XLEN + 1);

  cnt_op_e         op;
  logic [XLEN-1:0] scan_vec, pop_vec;
  logic [CW-1:0]   lz_cnt, pop_cnt, sel_cnt;

  assign op = cnt_op_e'(op_i);

  bcu_prep #(.XLEN(XLEN)) u_prep (
    .src_i (src_i),
    .op_i  (op),
    .word_i(word_i),
    .scan_o(scan_vec),
    .pop_o (pop_vec)
  );

  bcu_lzc #(.W(XLEN), .CW(CW)) u_lzc (
    .vec_i(scan_vec),
    .cnt_o(lz_cnt)
  );

  bcu_popcnt #(.W(XLEN), .CW(CW)) u_pop (
    .vec_i(pop_vec),
    .cnt_o(pop_cnt)
  );

  always_comb begin
    unique case (op)
      OP_LEAD, OP_TRAIL: sel_cnt = lz_cnt;
      OP_POP:            sel_cnt = pop_cnt;
      default:           sel_cnt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      count_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) count_o <= {{(XLEN-CW){1'b0}}, sel_cnt};
    end
  end

  p_valid_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_count_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(count_o));
  p_count_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> count_o <= XLEN'(XLEN));
  p_word_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i && XLEN > WORD_W) |=> count_o <= XLEN'(WORD_W));
  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=> count_o == '0);
  p_zero_lead_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && !word_i && src_i == '0) |=> count_o == XLEN'(XLEN));
  p_zero_trail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && !word_i && src_i == '0) |=> count_o == XLEN'(XLEN));
  p_bit0_trail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && src_i[0]) |=> count_o == '0);
endmodule

// File: tb/bit_count_unit_test.sv
`timescale 1ns/1ps
module bit_count_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0;
  logic        word = 1'b0;
  logic [63:0] src = '0;
  logic        valid_o64, valid_o32;
  logic [63:0] count_o64;
  logic [31:0] count_o32;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bit_count_unit #(.XLEN(64)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .word_i(word),
    .src_i(src), .valid_o(valid_o64), .count_o(count_o64)
  );

  bit_count_unit #(.XLEN(32)) uut_n32 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .word_i(word),
    .src_i(src[31:0]), .valid_o(valid_o32), .count_o(count_o32)
  );

  function automatic int model(logic [63:0] v, int op_v, int w);
    int r;
    if (op_v == 3) return 0;
    if (op_v == 2) begin
      r = 0;
      for (int i = 0; i < w; i++) r += int'(v[i]);
      return r;
    end
    r = w;
    if (op_v == 0) begin
      for (int i = 0; i < w; i++) if (v[i]) r = w - 1 - i;
    end else begin
      for (int i = w - 1; i >= 0; i--) if (v[i]) r = i;
    end
    return r;
  endfunction

  function automatic string tag_of(int op_v, bit w, logic [63:0] v);
    if (op_v == 3) return "R9";
    if (w && v[63:32] != 0) return "R7";
    case ({w, 2'(op_v)})
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b100: return "R4";
      3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] v, int op_v, bit w);
    @(negedge clk);
    src = v; op = 2'(op_v); word = w; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R8 valid_o", 64'(valid_o64), 64'd1);
    check(tag_of(op_v, w, v), count_o64, 64'(model(v, op_v, w ? 32 : 64)));
    check(op_v == 3 ? "R9" : "R11", 64'(count_o32), 64'(model(v, op_v, 32)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 valid_o", 64'(valid_o64), 64'd0);
    check("R10 count_o", count_o64, 64'd0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 64; p++) apply(64'd1 << p, o, w[0]);
        apply(64'd0, o, w[0]);
        apply('1, o, w[0]);
      end
    end

    // R7: same low word under different upper words
    for (int o = 0; o < 3; o++) begin
      apply(64'hFFFF_FFFF_0000_0000, o, 1'b1);
      apply(64'h8000_0001_0001_0000, o, 1'b1);
      apply(64'h0000_0000_0001_0000, o, 1'b1);
    end

    // R8: count holds and valid_o drops while valid_i is low
    apply(64'h0000_0100_0000_0000, 0, 1'b0);
    @(negedge clk);
    src = '1; op = 2'd2;
    @(negedge clk);
    check("R8 idle valid_o", 64'(valid_o64), 64'd0);
    check("R8 hold count_o", count_o64, 64'd23);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (n % 5 == 0) v = v & {$urandom, $urandom};
      apply(v, n % 4, n[2]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule